// File: doc/BRIEF.md
# E3 Transmit Overhead Inserter

This block sits in the transmit path of an E3 framer that uses the nine-row structured frame. A byte-wide payload stream arrives with a valid strobe and a frame-start flag. The row and column of each byte come with it on position inputs. Where a byte falls in an overhead location, the block overwrites it: the two alignment bytes, the parity byte, the path trace byte, the maintenance byte, the operator byte and the general-purpose channel byte. Every other byte goes through unchanged. One registered stage holds the result. The valid strobe and frame-start flag are delayed by the same stage.

The parity byte is a bitwise XOR over a complete frame. It is taken from a tap that returns the finished outgoing stream after any later processing, and the result is inserted into the following frame. The operator byte and the channel byte each have a source selector. One source for both is a shared serial-link byte, which is fetched only once per frame. With frame generation switched off, the stream passes through untouched.

Top module: `e3_oh_inserter`

## Requirements
- R1: Output data, `out_valid` and `out_sof` follow the inputs with exactly one clock cycle of latency. `out_sof` is high only together with `out_valid`.
- R2: When generation is on, the byte at row 0 column 0 is output as F6h and the byte at row 0 column 1 as 28h. Rows and columns are counted from 0.
- R3: The byte at row 1 column 0 is the XOR of every valid tap byte of the most recent complete tap frame. A tap frame runs from one `tap_sof` to the next. Before the first complete tap frame the value is 00h.
- R4: The byte at row 2 column 0 is taken from `tr_byte`, and the byte at row 3 column 0 from `ma_byte`.
- R5: The byte at row 4 column 0 is selected by `nr_sel`: 00 gives `nr_reg`, 01 gives `feac_byte`, 10 gives the serial-link byte and 11 gives `nr_reg`.
- R6: The byte at row 5 column 0 is selected by `gc_sel`: 0 gives `gc_reg` and 1 gives the serial-link byte.
- R7: `hdlc_req` is high in exactly the one cycle per frame in which `hdlc_byte` is sampled.
  - If row 4 uses the link, the byte is sampled at row 4 and the same byte is repeated at row 5 when row 5 also uses the link.
  - If only row 5 uses the link, the byte is sampled at row 5.
  - With no link source selected, `hdlc_req` stays low.
- R8: With `gen_en` low, every byte is output unchanged and `hdlc_req` stays low.
- R9: Payload bytes pass unchanged. Cycles with `in_valid` low produce no output byte, and tap cycles with `tap_valid` low do not enter the parity.
- R10: During reset, `out_valid`, `out_sof` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Enables overhead overwriting |
| nr_sel | input | 2 | Source of the row-4 byte |
| nr_reg | input | 8 | Register value for the row-4 byte |
| gc_sel | input | 1 | Source of the row-5 byte |
| gc_reg | input | 8 | Register value for the row-5 byte |
| tr_byte | input | 8 | Path trace byte |
| ma_byte | input | 8 | Maintenance byte from the composer |
| feac_byte | input | 8 | Alarm/command channel byte |
| hdlc_byte | input | 8 | Serial-link controller byte |
| hdlc_req | output | 1 | Strobe: serial-link byte consumed this cycle |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_row | input | $clog2(ROWS) | Row of the input byte |
| in_col | input | $clog2(COLS) | Column of the input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_data | output | 8 | Output byte |
| tap_valid | input | 1 | Tap byte valid |
| tap_sof | input | 1 | Tap byte is the first of a frame |
| tap_data | input | 8 | Finished outgoing byte fed back for parity |

## Verification
Two things happen in the same cycle when one tap frame starts. The parity of the frame that just ended is latched, and the accumulator is seeded with the first byte of the new frame. The bench drives frames back-to-back with no idle cycle at the boundary, and also with idle cycles scattered through the frames. It judges the result by the parity byte of the next frame, which must equal the XOR of every expected byte the bench predicted for the frame before. The second overlap is when both link-sourced rows are selected in one frame. The bench changes `hdlc_byte` on every cycle, so a second fetch would show up either as a second request strobe or as a different byte at row 5.

// File: rtl/e3_oh_pkg.sv
package e3_oh_pkg;

  typedef enum logic [2:0] {
    SLOT_PAY, SLOT_FA1, SLOT_FA2, SLOT_EM,
    SLOT_TR,  SLOT_MA,  SLOT_NR,  SLOT_GC
  } slot_e;

  localparam logic [7:0] FAW_FIRST  = 8'hF6;
  localparam logic [7:0] FAW_SECOND = 8'h28;

  localparam logic [1:0] NR_FROM_REG  = 2'b00;
  localparam logic [1:0] NR_FROM_FEAC = 2'b01;
  localparam logic [1:0] NR_FROM_LINK = 2'b10;

  // Parity step: one byte folded into a running column parity
  function automatic logic [7:0] bip8_fold(input logic [7:0] acc,
                                           input logic [7:0] b);
    return acc ^ b;
  endfunction

  // Position to overhead slot
  function automatic slot_e slot_of(input int unsigned row,
                                    input int unsigned col);
    slot_e s;
    s = SLOT_PAY;
    if (row == 0 && col == 0)      s = SLOT_FA1;
    else if (row == 0 && col == 1) s = SLOT_FA2;
    else if (col == 0) begin
      case (row)
        1: s = SLOT_EM;
        2: s = SLOT_TR;
        3: s = SLOT_MA;
        4: s = SLOT_NR;
        5: s = SLOT_GC;
        default: s = SLOT_PAY;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/e3_oh_slot_decode.sv
module e3_oh_slot_decode
  import e3_oh_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 6
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output slot_e            slot,
  output logic             is_oh
);

  always_comb begin
    slot  = slot_of(32'(row), 32'(col));
    is_oh = (slot != SLOT_PAY);
  end

endmodule

// File: rtl/e3_oh_bip8.sv
module e3_oh_bip8
  import e3_oh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tap_valid,
  input  logic       tap_sof,
  input  logic [7:0] tap_data,
  output logic [7:0] bip,
  output logic       latch_evt
);

  logic [7:0] acc;

  assign latch_evt = tap_valid && tap_sof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= 8'h00;
      bip <= 8'h00;
    end else if (tap_valid) begin
      if (tap_sof) begin
        bip <= acc;
        acc <= tap_data;
      end else begin
        acc <= bip8_fold(acc, tap_data);
      end
    end
  end

  // R3
  bip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable(bip));

  // R9
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tap_valid |=> $stable(acc));

endmodule

// File: rtl/e3_oh_src_mux.sv
module e3_oh_src_mux
  import e3_oh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       frame_start,
  input  slot_e      slot,
  input  logic [7:0] bip,
  input  logic [7:0] tr_byte,
  input  logic [7:0] ma_byte,
  input  logic [1:0] nr_sel,
  input  logic [7:0] nr_reg,
  input  logic [7:0] feac_byte,
  input  logic       gc_sel,
  input  logic [7:0] gc_reg,
  input  logic [7:0] hdlc_byte,
  output logic [7:0] oh_byte,
  output logic       hdlc_req
);

  logic       nr_link;
  logic       link_taken;
  logic [7:0] link_hold;
  logic [7:0] nr_byte;
  logic [7:0] gc_byte;

  assign nr_link  = (nr_sel == NR_FROM_LINK);
  assign hdlc_req = go && ((slot == SLOT_NR && nr_link) ||
                           (slot == SLOT_GC && gc_sel && !nr_link));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_taken <= 1'b0;
      link_hold  <= 8'h00;
    end else begin
      if (frame_start) link_taken <= 1'b0;
      if (hdlc_req) begin
        link_taken <= 1'b1;
        link_hold  <= hdlc_byte;
      end
    end
  end

  always_comb begin
    case (nr_sel)
      NR_FROM_FEAC: nr_byte = feac_byte;
      NR_FROM_LINK: nr_byte = hdlc_byte;
      default:      nr_byte = nr_reg;
    endcase
    if (!gc_sel)      gc_byte = gc_reg;
    else if (nr_link) gc_byte = link_hold;
    else              gc_byte = hdlc_byte;

    case (slot)
      SLOT_FA1: oh_byte = FAW_FIRST;
      SLOT_FA2: oh_byte = FAW_SECOND;
      SLOT_EM:  oh_byte = bip;
      SLOT_TR:  oh_byte = tr_byte;
      SLOT_MA:  oh_byte = ma_byte;
      SLOT_NR:  oh_byte = nr_byte;
      SLOT_GC:  oh_byte = gc_byte;
      default:  oh_byte = 8'h00;
    endcase
  end

  // R7
  one_fetch_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdlc_req && !frame_start) |-> !link_taken);

  // R7
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdlc_req |=> (link_hold == $past(hdlc_byte)));

endmodule

// File: rtl/e3_oh_inserter.sv
module e3_oh_inserter
  import e3_oh_pkg::*;
#(
  parameter int ROWS = 9,
  parameter int COLS = 59
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    gen_en,
  input  logic [1:0]              nr_sel,
  input  logic [7:0]              nr_reg,
  input  logic                    gc_sel,
  input  logic [7:0]              gc_reg,
  input  logic [7:0]              tr_byte,
  input  logic [7:0]              ma_byte,
  input  logic [7:0]              feac_byte,
  input  logic [7:0]              hdlc_byte,
  output logic                    hdlc_req,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic [$clog2(ROWS)-1:0] in_row,
  input  logic [$clog2(COLS)-1:0] in_col,
  input  logic [7:0]              in_data,
  output logic                    out_valid,
  output logic                    out_sof,
  output logic [7:0]              out_data,
  input  logic                    tap_valid,
  input  logic                    tap_sof,
  input  logic [7:0]              tap_data
);

  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  slot_e      slot;
  logic       is_oh;
  logic       go;
  logic       frame_start;
  logic [7:0] bip;
  logic       bip_latch;
  logic [7:0] oh_byte;

  assign go          = in_valid && gen_en;
  assign frame_start = in_valid && in_sof;

  e3_oh_slot_decode #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dec (
    .row   (in_row),
    .col   (in_col),
    .slot  (slot),
    .is_oh (is_oh)
  );

  e3_oh_bip8 u_bip (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_valid (tap_valid),
    .tap_sof   (tap_sof),
    .tap_data  (tap_data),
    .bip       (bip),
    .latch_evt (bip_latch)
  );

  e3_oh_src_mux u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .frame_start (frame_start),
    .slot        (slot),
    .bip         (bip),
    .tr_byte     (tr_byte),
    .ma_byte     (ma_byte),
    .nr_sel      (nr_sel),
    .nr_reg      (nr_reg),
    .feac_byte   (feac_byte),
    .gc_sel      (gc_sel),
    .gc_reg      (gc_reg),
    .hdlc_byte   (hdlc_byte),
    .oh_byte     (oh_byte),
    .hdlc_req    (hdlc_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_data  <= 8'h00;
    end else begin
      out_valid <= in_valid;
      out_sof   <= frame_start;
      out_data  <= (go && is_oh) ? oh_byte : in_data;
    end
  end

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  idle_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R1
  sof_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  // R2
  faw_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && in_row == '0 && in_col == '0) |=> (out_data == 8'hF6));

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !gen_en) |=> (out_data == $past(in_data)));

  // R8
  no_fetch_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> !hdlc_req);

endmodule

// File: tb/e3_oh_inserter_tb.sv
module e3_oh_inserter_tb;

  localparam int ROWS = 9;
  localparam int COLS = 59;
  localparam int WATCHDOG = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gen_en = 1'b0;
  logic [1:0] nr_sel = 2'b00;
  logic [7:0] nr_reg = 8'h00;
  logic       gc_sel = 1'b0;
  logic [7:0] gc_reg = 8'h00;
  logic [7:0] tr_byte = 8'h00;
  logic [7:0] ma_byte = 8'h00;
  logic [7:0] feac_byte = 8'h00;
  logic [7:0] hdlc_byte = 8'h00;
  logic       hdlc_req;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic [3:0] in_row = '0;
  logic [5:0] in_col = '0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic       out_sof;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  e3_oh_inserter #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk (clk), .rst_n (rst_n), .gen_en (gen_en),
    .nr_sel (nr_sel), .nr_reg (nr_reg), .gc_sel (gc_sel), .gc_reg (gc_reg),
    .tr_byte (tr_byte), .ma_byte (ma_byte), .feac_byte (feac_byte),
    .hdlc_byte (hdlc_byte), .hdlc_req (hdlc_req),
    .in_valid (in_valid), .in_sof (in_sof), .in_row (in_row), .in_col (in_col),
    .in_data (in_data),
    .out_valid (out_valid), .out_sof (out_sof), .out_data (out_data),
    .tap_valid (out_valid), .tap_sof (out_sof), .tap_data (out_data)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] q_data[$];
  logic       q_sof[$];
  string      q_tag[$];

  logic [7:0] prev_xor = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor: pops expected bytes as the design emits them
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R9", int'(out_data), -1);
      end else begin
        logic [7:0] ed;
        logic       es;
        string      et;
        ed = q_data.pop_front();
        es = q_sof.pop_front();
        et = q_tag.pop_front();
        check(out_data == ed, et, int'(out_data), int'(ed));
        check(out_sof == es, "R1", int'(out_sof), int'(es));
      end
    end
  end

  // Drives one frame and pushes expected output; gaps add idle cycles
  task automatic send_frame(input bit gaps);
    logic [7:0] run;
    logic [7:0] link_cap;
    int         req_cnt;
    int         exp_req;
    run      = 8'h00;
    link_cap = 8'h00;
    req_cnt  = 0;
    exp_req  = (gen_en && (nr_sel == 2'b10 || gc_sel)) ? 1 : 0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        logic [7:0] e;
        string      t;
        if (gaps && ($urandom % 7 == 0)) begin
          @(posedge clk); #1;
          in_valid  = 1'b0;
          in_sof    = 1'b1;
          in_data   = 8'($urandom);
          hdlc_byte = 8'($urandom);
          #2;
          if (hdlc_req) req_cnt++;
        end
        @(posedge clk); #1;
        in_valid  = 1'b1;
        in_sof    = (r == 0 && c == 0);
        in_row    = 4'(r);
        in_col    = 6'(c);
        in_data   = 8'($urandom);
        hdlc_byte = 8'($urandom);
        e = in_data;
        t = "R9";
        if (gen_en) begin
          if (r == 0 && c == 0)      begin e = 8'hF6; t = "R2"; end
          else if (r == 0 && c == 1) begin e = 8'h28; t = "R2"; end
          else if (c == 0 && r == 1) begin e = prev_xor; t = "R3"; end
          else if (c == 0 && r == 2) begin e = tr_byte; t = "R4"; end
          else if (c == 0 && r == 3) begin e = ma_byte; t = "R4"; end
          else if (c == 0 && r == 4) begin
            t = "R5";
            if (nr_sel == 2'b01)      e = feac_byte;
            else if (nr_sel == 2'b10) begin e = hdlc_byte; link_cap = hdlc_byte; end
            else                      e = nr_reg;
          end else if (c == 0 && r == 5) begin
            t = "R6";
            if (!gc_sel)              e = gc_reg;
            else if (nr_sel == 2'b10) begin e = link_cap; t = "R7"; end
            else                      e = hdlc_byte;
          end
        end else begin
          t = "R8";
        end
        q_data.push_back(e);
        q_sof.push_back(r == 0 && c == 0);
        q_tag.push_back(t);
        run = run ^ e;
        #2;
        if (hdlc_req) req_cnt++;
      end
    end
    prev_xor = run;
    check(req_cnt == exp_req, gen_en ? "R7" : "R8", req_cnt, exp_req);
  endtask

  task automatic set_cfg(input bit g, input logic [1:0] ns, input bit gs);
    gen_en    = g;
    nr_sel    = ns;
    gc_sel    = gs;
    nr_reg    = 8'($urandom);
    gc_reg    = 8'($urandom);
    tr_byte   = 8'($urandom);
    ma_byte   = 8'($urandom);
    feac_byte = 8'($urandom);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        check(1'b0, "watchdog", cyc, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    in_valid = 1'b1;
    in_data  = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10", int'(out_valid), 0);
    check(out_sof == 1'b0, "R10", int'(out_sof), 0);
    check(out_data == 8'h00, "R10", int'(out_data), 0);
    in_valid = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;

    set_cfg(1'b1, 2'b00, 1'b0); send_frame(1'b0);  // R3 first EM is 00h
    set_cfg(1'b1, 2'b01, 1'b1); send_frame(1'b1);
    set_cfg(1'b1, 2'b10, 1'b0); send_frame(1'b0);
    set_cfg(1'b1, 2'b10, 1'b1); send_frame(1'b1);  // R7 shared byte
    set_cfg(1'b0, 2'b10, 1'b1); send_frame(1'b1);  // R8 bypass
    set_cfg(1'b1, 2'b11, 1'b1); send_frame(1'b0);  // R5 code 11
    set_cfg(1'b1, 2'b00, 1'b0); send_frame(1'b0);  // R3 back-to-back
    set_cfg(1'b1, 2'b01, 1'b0); send_frame(1'b1);

    @(posedge clk); #1;
    in_valid = 1'b0;
    in_sof   = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(q_data.size() == 0, "R1", q_data.size(), 0);
    done = 1'b1;
    finish_run();
  end

endmodule